// File: doc/BRIEF.md
# Rotating-Parity Small-Write Sequencer

This block turns one block-write request into the word-level disk operations that a striped array with rotating parity needs to keep its parity consistent. The array has `NDATA` data drives plus one parity drive per stripe, so `NDATA+1` physical drives in all. The parity block of a stripe is the XOR of that stripe's data blocks, and the drive holding it moves from stripe to stripe. A request gives a stripe number, a logical data-block index within the stripe and an update mode. The new block's words are fetched from the requester through a word-index/word-data port.

In delta mode the sequencer reads the old data block and the old parity block, folds both into an XOR accumulator, writes the new data, and then writes accumulator XOR new data as the new parity. In full mode it instead reads the other `NDATA-1` data blocks of the stripe and folds those into the accumulator. The write phase is the same in both modes. Every disk operation moves one word. It is held on the request port until the disk acknowledges it, and read data is taken in the acknowledge cycle.

Top module: `r5_small_write`

## Requirements
- R1: After reset, and whenever the block is idle, `busy`, `done` and `dk_req` are 0.
- R2: Drives are numbered 0 to NDATA. The parity block of stripe s lies on drive NDATA - (s mod (NDATA+1)), and the parity write of a request goes to that drive.
- R3: Logical data index d of a stripe lies on drive d when d is below that stripe's parity drive, and on drive d+1 otherwise. The data write goes to that drive, and afterwards it holds the new block.
- R4: In delta mode (`mode`=0) the reads cover exactly the target data drive and the parity drive, in ascending drive order, with words 0 to WORDS-1 ascending on each drive.
- R5: In full mode (`mode`=1) the reads cover exactly the data drives other than the target, in ascending drive order, with words 0 to WORDS-1 ascending on each drive. Neither the target drive nor the parity drive is read.
- R6: Every read is acknowledged before the first write is issued. All data-block words (0 upward) are written before any parity-block word (0 upward).
- R7: After a request completes, the XOR of the same word over all NDATA+1 drives of the stripe is 0, given that it was 0 before.
- R8: A request on the disk port keeps its direction, drive and word unchanged until `dk_ack` is sampled high. `dk_rdata` is taken in that same cycle.
- R9: `done` is high for exactly one cycle, in the cycle after the final parity word is acknowledged, and `busy` is 0 in that cycle.
- R10: `start` is ignored while `busy` is high: the operation in flight and the disk traffic are unchanged, and no second operation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a request when idle |
| mode | input | 1 | 0 = delta update, 1 = full recompute |
| stripe | input | SW | Stripe number of the request |
| data_idx | input | clog2(NDATA) | Logical data-block index in the stripe |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| nw_idx | output | clog2(WORDS) | Word index of the new block being fetched |
| nw_data | input | WW | New block word at `nw_idx` |
| dk_req | output | 1 | Disk word operation valid |
| dk_wr | output | 1 | 1 = write, 0 = read |
| dk_drive | output | clog2(NDATA+1) | Physical drive |
| dk_stripe | output | SW | Stripe (block address on the drive) |
| dk_word | output | clog2(WORDS) | Word within the block |
| dk_wdata | output | WW | Write data |
| dk_ack | input | 1 | Disk accepts the current operation |
| dk_rdata | input | WW | Read data, valid with `dk_ack` |

## Verification
Requests are issued in both modes across stripes 0 to 13, so the parity drive takes all five positions. Target indices fall both below and above the parity drive, which separates the two branches of the drive mapping and exposes any skipped or duplicated read. The disk answers with acknowledge delays of 0 to 2 cycles, which tells a design that holds its request and samples data on acknowledge apart from one that assumes a fixed latency. The array starts with consistent random contents, so a wrong fold shows up as a stripe whose XOR is no longer zero. A start pulse with different fields in the middle of an operation tells an engine that ignores it apart from one that relatches its request or queues a second run.

// File: rtl/r5_pkg.sv
`timescale 1ns/1ps
package r5_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WDATA = 2'd2,
        PH_WPAR  = 2'd3
    } phase_e;
endpackage

// File: rtl/r5_stripe_map.sv
`timescale 1ns/1ps
// Parity rotation and logical-to-physical data drive mapping.
module r5_stripe_map #(
    parameter int NDATA = 4,
    parameter int SW    = 8
) (
    input  logic [SW-1:0]              stripe,
    input  logic [$clog2(NDATA)-1:0]   didx,
    output logic [$clog2(NDATA+1)-1:0] par_drv,
    output logic [$clog2(NDATA+1)-1:0] dat_drv
);
    localparam int DRW = $clog2(NDATA + 1);

    int unsigned           rem;
    logic [DRW-1:0]        dx;

    always_comb begin
        rem     = int'(stripe) % (NDATA + 1);
        par_drv = DRW'(NDATA - int'(rem));
        dx      = DRW'(didx);
        dat_drv = (dx < par_drv) ? dx : dx + 1'b1;
    end
endmodule

// File: rtl/r5_xor_acc.sv
`timescale 1ns/1ps
// One block of XOR accumulation, one word updated per cycle.
module r5_xor_acc #(
    parameter int WORDS = 8,
    parameter int WW    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     upd,
    input  logic [$clog2(WORDS)-1:0] idx,
    input  logic [WW-1:0]            din,
    output logic [WW-1:0]            dout
);
    localparam int WIW = $clog2(WORDS);

    logic [WW-1:0] acc_q [WORDS];
    logic [WW-1:0] acc_d [WORDS];

    always_comb begin
        for (int i = 0; i < WORDS; i++) begin
            if (clr)
                acc_d[i] = '0;
            else if (upd && idx == WIW'(i))
                acc_d[i] = acc_q[i] ^ din;
            else
                acc_d[i] = acc_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) acc_q[i] <= '0;
        end else begin
            for (int i = 0; i < WORDS; i++) acc_q[i] <= acc_d[i];
        end
    end

    assign dout = acc_q[idx];
endmodule

// File: rtl/r5_seq.sv
`timescale 1ns/1ps
// Operation sequencer: read phase over physical drives, then data write, then parity write.
module r5_seq
    import r5_pkg::*;
#(
    parameter int NDATA = 4,
    parameter int WORDS = 8,
    parameter int SW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       mode,
    input  logic [SW-1:0]              stripe,
    input  logic [$clog2(NDATA)-1:0]   didx,
    input  logic [$clog2(NDATA+1)-1:0] par_drv,
    input  logic [$clog2(NDATA+1)-1:0] dat_drv,
    input  logic                       dk_ack,
    output logic                       busy,
    output logic                       done,
    output logic                       dk_req,
    output logic                       dk_wr,
    output logic [$clog2(NDATA+1)-1:0] dk_drive,
    output logic [$clog2(WORDS)-1:0]   word,
    output logic                       wr_par,
    output logic [SW-1:0]              stripe_q,
    output logic [$clog2(NDATA)-1:0]   didx_q,
    output logic                       acc_clr,
    output logic                       acc_upd
);
    localparam int DRW = $clog2(NDATA + 1);
    localparam int DIW = $clog2(NDATA);
    localparam int WIW = $clog2(WORDS);
    localparam logic [WIW-1:0] LAST_WORD = WIW'(WORDS - 1);
    localparam logic [DRW-1:0] LAST_DRV  = DRW'(NDATA);

    typedef struct packed {
        phase_e         ph;
        logic [DRW-1:0] drv;
        logic [WIW-1:0] word;
        logic           full;
        logic [SW-1:0]  stripe;
        logic [DIW-1:0] didx;
        logic           done;
    } seq_t;

    seq_t q, d;
    logic pick;
    logic last_word;
    logic last_drv;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        acc_clr   = 1'b0;
        acc_upd   = 1'b0;
        dk_req    = 1'b0;
        dk_wr     = 1'b0;
        dk_drive  = q.drv;
        last_word = (q.word == LAST_WORD);
        last_drv  = (q.drv == LAST_DRV);
        if (q.full)
            pick = (q.drv != par_drv) && (q.drv != dat_drv);
        else
            pick = (q.drv == par_drv) || (q.drv == dat_drv);

        unique case (q.ph)
            PH_IDLE: begin
                if (start) begin
                    d.ph     = PH_READ;
                    d.drv    = '0;
                    d.word   = '0;
                    d.full   = mode;
                    d.stripe = stripe;
                    d.didx   = didx;
                    acc_clr  = 1'b1;
                end
            end
            PH_READ: begin
                if (!pick) begin
                    if (last_drv) begin
                        d.ph   = PH_WDATA;
                        d.word = '0;
                    end else begin
                        d.drv = q.drv + 1'b1;
                    end
                end else begin
                    dk_req = 1'b1;
                    if (dk_ack) begin
                        acc_upd = 1'b1;
                        if (last_word) begin
                            d.word = '0;
                            if (last_drv) d.ph  = PH_WDATA;
                            else          d.drv = q.drv + 1'b1;
                        end else begin
                            d.word = q.word + 1'b1;
                        end
                    end
                end
            end
            PH_WDATA: begin
                dk_req   = 1'b1;
                dk_wr    = 1'b1;
                dk_drive = dat_drv;
                if (dk_ack) begin
                    if (last_word) begin
                        d.ph   = PH_WPAR;
                        d.word = '0;
                    end else begin
                        d.word = q.word + 1'b1;
                    end
                end
            end
            PH_WPAR: begin
                dk_req   = 1'b1;
                dk_wr    = 1'b1;
                dk_drive = par_drv;
                if (dk_ack) begin
                    if (last_word) begin
                        d.ph   = PH_IDLE;
                        d.word = '0;
                        d.done = 1'b1;
                    end else begin
                        d.word = q.word + 1'b1;
                    end
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.ph     <= PH_IDLE;
            q.drv    <= '0;
            q.word   <= '0;
            q.full   <= 1'b0;
            q.stripe <= '0;
            q.didx   <= '0;
            q.done   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.ph != PH_IDLE);
    assign done     = q.done;
    assign word     = q.word;
    assign wr_par   = (q.ph == PH_WPAR);
    assign stripe_q = q.stripe;
    assign didx_q   = q.didx;
endmodule

// File: rtl/r5_small_write.sv
`timescale 1ns/1ps
// Top: small-write parity update engine for a rotating-parity array.
module r5_small_write #(
    parameter int NDATA = 4,
    parameter int WORDS = 8,
    parameter int WW    = 32,
    parameter int SW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       mode,
    input  logic [SW-1:0]              stripe,
    input  logic [$clog2(NDATA)-1:0]   data_idx,
    output logic                       busy,
    output logic                       done,
    output logic [$clog2(WORDS)-1:0]   nw_idx,
    input  logic [WW-1:0]              nw_data,
    output logic                       dk_req,
    output logic                       dk_wr,
    output logic [$clog2(NDATA+1)-1:0] dk_drive,
    output logic [SW-1:0]              dk_stripe,
    output logic [$clog2(WORDS)-1:0]   dk_word,
    output logic [WW-1:0]              dk_wdata,
    input  logic                       dk_ack,
    input  logic [WW-1:0]              dk_rdata
);
    localparam int DRW = $clog2(NDATA + 1);
    localparam int DIW = $clog2(NDATA);
    localparam int WIW = $clog2(WORDS);

    logic [DRW-1:0] par_drv;
    logic [DRW-1:0] dat_drv;
    logic [SW-1:0]  stripe_q;
    logic [DIW-1:0] didx_q;
    logic [WIW-1:0] word;
    logic           wr_par;
    logic           acc_clr;
    logic           acc_upd;
    logic [WW-1:0]  acc_word;

    r5_stripe_map #(.NDATA(NDATA), .SW(SW)) u_map (
        .stripe  (stripe_q),
        .didx    (didx_q),
        .par_drv (par_drv),
        .dat_drv (dat_drv)
    );

    r5_seq #(.NDATA(NDATA), .WORDS(WORDS), .SW(SW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mode     (mode),
        .stripe   (stripe),
        .didx     (data_idx),
        .par_drv  (par_drv),
        .dat_drv  (dat_drv),
        .dk_ack   (dk_ack),
        .busy     (busy),
        .done     (done),
        .dk_req   (dk_req),
        .dk_wr    (dk_wr),
        .dk_drive (dk_drive),
        .word     (word),
        .wr_par   (wr_par),
        .stripe_q (stripe_q),
        .didx_q   (didx_q),
        .acc_clr  (acc_clr),
        .acc_upd  (acc_upd)
    );

    r5_xor_acc #(.WORDS(WORDS), .WW(WW)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .upd   (acc_upd),
        .idx   (word),
        .din   (dk_rdata),
        .dout  (acc_word)
    );

    assign nw_idx    = word;
    assign dk_word   = word;
    assign dk_stripe = stripe_q;
    assign dk_wdata  = wr_par ? (acc_word ^ nw_data) : nw_data;
endmodule

// File: rtl/r5_small_write_chk.sv
`timescale 1ns/1ps
// Protocol and ordering checker bound to the top module.
module r5_small_write_chk #(
    parameter int NDATA = 4,
    parameter int WORDS = 8,
    parameter int SW    = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       start,
    input logic [SW-1:0]              stripe,
    input logic [$clog2(NDATA)-1:0]   data_idx,
    input logic                       busy,
    input logic                       done,
    input logic                       dk_req,
    input logic                       dk_wr,
    input logic [$clog2(NDATA+1)-1:0] dk_drive,
    input logic [$clog2(WORDS)-1:0]   dk_word,
    input logic                       dk_ack
);
    localparam int DRW = $clog2(NDATA + 1);
    localparam int DIW = $clog2(NDATA);
    localparam int WIW = $clog2(WORDS);

    logic [SW-1:0]  c_stripe;
    logic [DIW-1:0] c_idx;
    logic           wrote_any;
    logic           data_wr_seen;
    logic [DRW-1:0] c_par;
    logic [DRW-1:0] c_dat;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_stripe     <= '0;
            c_idx        <= '0;
            wrote_any    <= 1'b0;
            data_wr_seen <= 1'b0;
        end else if (start && !busy) begin
            c_stripe     <= stripe;
            c_idx        <= data_idx;
            wrote_any    <= 1'b0;
            data_wr_seen <= 1'b0;
        end else if (dk_req && dk_ack && dk_wr) begin
            wrote_any <= 1'b1;
            if (dk_drive == c_dat && dk_word == WIW'(WORDS - 1)) data_wr_seen <= 1'b1;
        end
    end

    always_comb begin
        c_par = DRW'(NDATA - (int'(c_stripe) % (NDATA + 1)));
        c_dat = (int'(c_idx) < int'(c_par)) ? DRW'(c_idx) : DRW'(int'(c_idx) + 1);
    end

    // R1: no disk traffic while idle
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dk_req);

    // R2 / R3: writes only to the mapped parity or data drive
    assert_write_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dk_req && dk_wr) |-> (dk_drive == c_par || dk_drive == c_dat));

    // R6: no read once a write was acknowledged
    assert_reads_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dk_req && !dk_wr) |-> !wrote_any);

    // R6: parity write only after the whole data block
    assert_parity_after_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dk_req && dk_wr && dk_drive == c_par) |-> data_wr_seen);

    // R8: request held until acknowledged
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dk_req && !dk_ack) |=> (dk_req && $stable(dk_wr) && $stable(dk_drive) && $stable(dk_word)));

    // R9: done is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done follows the last acknowledged write word and leaves the block idle
    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dk_req && dk_ack && dk_wr && dk_drive == c_par && dk_word == WIW'(WORDS - 1)) |=> (done && !busy));
endmodule

bind r5_small_write r5_small_write_chk #(.NDATA(NDATA), .WORDS(WORDS), .SW(SW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .stripe   (stripe),
    .data_idx (data_idx),
    .busy     (busy),
    .done     (done),
    .dk_req   (dk_req),
    .dk_wr    (dk_wr),
    .dk_drive (dk_drive),
    .dk_word  (dk_word),
    .dk_ack   (dk_ack)
);

// File: tb/r5_small_write_test.sv
`timescale 1ns/1ps
module r5_small_write_test;
    localparam int NDATA = 4;
    localparam int NDRV  = NDATA + 1;
    localparam int WORDS = 8;
    localparam int WW    = 32;
    localparam int SW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic [SW-1:0] stripe = '0;
    logic [1:0]    data_idx = '0;
    logic          busy, done;
    logic [2:0]    nw_idx;
    logic [WW-1:0] nw_data;
    logic          dk_req, dk_wr;
    logic [2:0]    dk_drive;
    logic [SW-1:0] dk_stripe;
    logic [2:0]    dk_word;
    logic [WW-1:0] dk_wdata;
    logic          dk_ack = 1'b0;
    logic [WW-1:0] dk_rdata = '0;

    logic [WW-1:0] mem [NDRV][16][WORDS];
    logic [WW-1:0] newblk [WORDS];
    logic [31:0]   lcg = 32'h1234_5678;

    int  n_checks = 0;
    int  n_fail = 0;
    int  cycles = 0;
    int  exp_q[$];
    bit  model_busy = 1'b0;
    bit  fin_pending = 1'b0;
    bit  cur_full = 1'b0;
    int  cur_par = 0;
    int  wait_cnt = 0;
    int  lat_ctr = 0;
    bit  held = 1'b0;
    int  held_op = 0;

    always #5 clk = ~clk;

    assign nw_data = newblk[nw_idx];

    r5_small_write #(.NDATA(NDATA), .WORDS(WORDS), .WW(WW), .SW(SW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .stripe(stripe),
        .data_idx(data_idx), .busy(busy), .done(done), .nw_idx(nw_idx),
        .nw_data(nw_data), .dk_req(dk_req), .dk_wr(dk_wr), .dk_drive(dk_drive),
        .dk_stripe(dk_stripe), .dk_word(dk_word), .dk_wdata(dk_wdata),
        .dk_ack(dk_ack), .dk_rdata(dk_rdata)
    );

    function automatic int par_of(int s);
        return NDATA - (s % NDRV);
    endfunction

    function automatic int phys_of(int d, int p);
        return (d < p) ? d : d + 1;
    endfunction

    function automatic logic [31:0] next_rand();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg ^ (lcg >> 13);
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                finish_run();
            end
        end
    end

    // per-clock reference comparison and disk responder (negedge, away from the active edge)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (fin_pending) begin
                    check(done == 1'b1, "R9 done pulse", done, 1);
                    check(busy == 1'b0, "R9 idle with done", busy, 0);
                    fin_pending = 1'b0;
                    model_busy  = 1'b0;
                end else begin
                    check(done == 1'b0, "R9 no stray done", done, 0);
                    check(busy == model_busy, "R10 busy vs model", busy, model_busy);
                end
                if (!model_busy)
                    check(dk_req == 1'b0, "R1 quiet when idle", dk_req, 0);

                if (dk_req) begin
                    int op;
                    op = int'(dk_wr) * 256 + int'(dk_drive) * 16 + int'(dk_word);
                    if (held)
                        check(op == held_op, "R8 request held until ack", op, held_op);
                    if (wait_cnt != 0) begin
                        dk_ack   = 1'b0;
                        wait_cnt = wait_cnt - 1;
                        held     = 1'b1;
                        held_op  = op;
                    end else begin
                        held   = 1'b0;
                        dk_ack = 1'b1;
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R6 unexpected op", op, 0);
                        end else begin
                            int e;
                            string tag;
                            e = exp_q.pop_front();
                            if (e >= 256) tag = ((e / 16) % 16 == cur_par) ? "R2 parity write" : "R3 data write";
                            else          tag = cur_full ? "R5 full read" : "R4 delta read";
                            check(op == e, tag, op, e);
                            check(dk_stripe == stripe_hold, "R2 stripe on disk port", dk_stripe, stripe_hold);
                            if (exp_q.size() == 0) fin_pending = 1'b1;
                        end
                        if (dk_wr)
                            mem[dk_drive][dk_stripe[3:0]][dk_word] = dk_wdata;
                        else
                            dk_rdata = mem[dk_drive][dk_stripe[3:0]][dk_word];
                        lat_ctr++;
                        wait_cnt = lat_ctr % 3;
                    end
                end else begin
                    dk_ack = 1'b0;
                    held   = 1'b0;
                end
            end
        end
    end

    logic [SW-1:0] stripe_hold = '0;

    task automatic init_mem();
        for (int s = 0; s < 16; s++) begin
            int p;
            p = par_of(s);
            for (int w = 0; w < WORDS; w++) begin
                logic [WW-1:0] x;
                x = '0;
                for (int dv = 0; dv < NDRV; dv++) begin
                    if (dv != p) begin
                        mem[dv][s][w] = next_rand();
                        x = x ^ mem[dv][s][w];
                    end
                end
                mem[p][s][w] = x;
            end
        end
    endtask

    task automatic check_mem(input int s, input int d);
        int p, dp;
        p  = par_of(s);
        dp = phys_of(d, p);
        for (int w = 0; w < WORDS; w++) begin
            logic [WW-1:0] x;
            check(mem[dp][s][w] == newblk[w], "R3 new data on mapped drive", mem[dp][s][w], newblk[w]);
            x = '0;
            for (int dv = 0; dv < NDRV; dv++) x = x ^ mem[dv][s][w];
            check(x == '0, "R7 stripe parity consistent", x, 0);
        end
    endtask

    task automatic run(input bit m, input int s, input int d, input bit poke);
        int p, dp, guard;
        p  = par_of(s);
        dp = phys_of(d, p);
        for (int w = 0; w < WORDS; w++) newblk[w] = next_rand();
        exp_q.delete();
        for (int dv = 0; dv < NDRV; dv++) begin
            bit sel;
            sel = m ? (dv != p && dv != dp) : (dv == p || dv == dp);
            if (sel) for (int w = 0; w < WORDS; w++) exp_q.push_back(dv * 16 + w);
        end
        for (int w = 0; w < WORDS; w++) exp_q.push_back(256 + dp * 16 + w);
        for (int w = 0; w < WORDS; w++) exp_q.push_back(256 + p * 16 + w);
        @(posedge clk); #2;
        start = 1'b1; mode = m; stripe = SW'(s); data_idx = 2'(d);
        cur_full = m; cur_par = p; stripe_hold = SW'(s);
        @(posedge clk); #2;
        start = 1'b0;
        model_busy = 1'b1;
        if (poke) begin
            repeat (4) @(posedge clk);
            #2;
            start = 1'b1; mode = ~m; stripe = SW'(s + 1); data_idx = 2'(d ^ 1);
            @(posedge clk); #2;
            start = 1'b0;
        end
        guard = 0;
        while (model_busy && guard < 3000) begin
            @(posedge clk);
            guard++;
        end
        check(!model_busy, "R9 operation completes", guard, 3000);
        check(exp_q.size() == 0, "R6 all expected ops issued", exp_q.size(), 0);
        repeat (3) @(posedge clk);
        check_mem(s, d);
    endtask

    initial begin
        for (int w = 0; w < WORDS; w++) newblk[w] = '0;
        init_mem();
        repeat (3) @(posedge clk);
        #2;
        check(busy == 1'b0 && done == 1'b0 && dk_req == 1'b0, "R1 reset state",
              {busy, done, dk_req}, 0);
        rst_n = 1'b1;
        // delta mode across all parity positions
        run(1'b0, 0, 0, 1'b0);
        run(1'b0, 1, 3, 1'b0);
        run(1'b0, 2, 1, 1'b0);
        run(1'b0, 3, 2, 1'b0);
        run(1'b0, 4, 0, 1'b0);
        run(1'b0, 7, 3, 1'b0);
        // full recompute mode
        run(1'b1, 5, 2, 1'b0);
        run(1'b1, 6, 0, 1'b0);
        run(1'b1, 9, 3, 1'b0);
        run(1'b1, 4, 3, 1'b0);
        run(1'b1, 13, 1, 1'b0);
        // start ignored while busy (R10)
        run(1'b0, 8, 2, 1'b1);
        run(1'b1, 11, 0, 1'b1);
        // same stripe updated twice in different modes
        run(1'b0, 2, 1, 1'b0);
        run(1'b1, 2, 1, 1'b0);
        finish_run();
    end
endmodule